// File: doc/BRIEF.md
# Enable-coded TFT scan timing generator

This block produces the complete scan for a TFT panel that has no separate sync lines and recovers line and frame boundaries from one data-enable wire alone. A free-running system clock is halved by a toggle stage to form the panel clock. That panel clock keeps running through reset. Horizontal and vertical position counters step once per panel clock. They walk a raster of `H_TOTAL` clocks per line and `V_TOTAL` lines per frame. The first `H_ACTIVE` clocks of the first `V_ACTIVE` lines are visible. Because the panel decodes its internal sync from the enable edges, every frame has exactly the same number of blanking clocks.

A pixel source is told which pixel to fetch through a request strobe with x/y coordinates. It answers `FETCH_LAT` panel clocks later on `pix_i`. The block then drives that pixel on the 18-bit panel bus with enable high. All panel-side outputs change at the clock edge where the panel clock falls, so they are stable around the rising edge on which the panel latches. Defaults suit an 800x600 panel with 860 clocks per line and 615 lines per frame.

Top module: `tft_de_timing`

## Requirements
- R1: `pclk_o` inverts on every rising edge of `clk_i`, giving a period of two `clk_i` cycles and a 50% duty cycle. It also keeps toggling while `rst_ni` is low.
- R2: `de_o`, `data_o`, `sof_o` and `req_o` change only at the `clk_i` edge where `pclk_o` goes from 1 to 0. They hold their value across the rising edge of `pclk_o`.
- R3: Every line lasts exactly `H_TOTAL` panel clocks. On a visible line, `de_o` is high for exactly `H_ACTIVE` consecutive panel clocks, and consecutive enable rises within a frame are `H_TOTAL` panel clocks apart.
- R4: Every frame lasts exactly `H_TOTAL*V_TOTAL` panel clocks, from one frame to the next. It contains exactly `V_ACTIVE` enable pulses, and `de_o` stays low for all `V_TOTAL-V_ACTIVE` blanking lines.
- R5: `sof_o` is high for exactly one panel clock per frame, in the same panel clock as the enable for pixel (0,0).
- R6: `req_o` is high for one panel clock per visible pixel. `req_x_o`/`req_y_o` carry that pixel's coordinates in raster order: x from 0 to `H_ACTIVE-1`, then the next y. The value on `pix_i` during the `FETCH_LAT`-th panel clock after the request appears unchanged on `data_o`, bit-for-bit, one panel clock later. At that time `de_o` is high, so `de_o` equals `req_o` delayed by `FETCH_LAT+1` panel clocks.
- R7: `data_o` is all zeros whenever `de_o` is low, whatever is on `pix_i`.
- R8: While `rst_ni` is low, `de_o`, `data_o`, `sof_o`, `req_o`, `req_x_o` and `req_y_o` are zero. The reset acts asynchronously. After release, the first panel clock edge issues the request for pixel (0,0). With `FETCH_LAT`=1, `sof_o` and `de_o` rise two panel clocks after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the panel pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset of counters and outputs (not the clock divider) |
| pix_i | input | 18 | Pixel from the source, {red[17:12], green[11:6], blue[5:0]} |
| pclk_o | output | 1 | Free-running panel pixel clock, panel latches on its rising edge |
| de_o | output | 1 | Panel data enable, high only on visible pixels |
| data_o | output | 18 | Panel pixel bus, zero during blanking |
| sof_o | output | 1 | One-panel-clock start-of-frame marker aligned with pixel (0,0) |
| req_o | output | 1 | Pixel fetch request to the source |
| req_x_o | output | $clog2(H_ACTIVE) | Column of the requested pixel, zero when no request |
| req_y_o | output | $clog2(V_ACTIVE) | Row of the requested pixel, zero when no request |

## Verification
The hardest case to reach is a reset that lands partway through a frame, at an arbitrary phase of the free-running divider. The bench must then show that the panel clock never paused, that the raster restarts cleanly at pixel (0,0), and that every later frame again has the exact blanking count. The bench overrides the raster to a 9x6 frame with a 6x4 visible area, so several whole frames fit in a short run. It drops reset at an odd offset inside the third frame and releases it after an odd number of system cycles. From there it re-measures each line and frame length with its own counters. A bench-side pixel source answers each request from the strobed coordinates and drives all-ones on `pix_i` when nothing is requested, so any blanking leak shows up on the bus.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;
  localparam int unsigned CHAN_W = 6;
  localparam int unsigned PIX_W  = 3 * CHAN_W;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/tft_clk_div.sv
// Free-running divide-by-two; deliberately outside reset so the panel clock never halts.
module tft_clk_div (
  input  logic clk_i,
  output logic pclk_o,
  output logic tick_o
);
  logic div_q;

  always_ff @(posedge clk_i) div_q <= ~div_q;

  assign pclk_o = div_q;
  // the coming clk_i edge is the falling edge of pclk_o
  assign tick_o = div_q;
endmodule

// File: rtl/tft_scan_cnt.sv
module tft_scan_cnt #(
  parameter int unsigned H_TOTAL = 860,
  parameter int unsigned V_TOTAL = 615,
  parameter int unsigned HW      = $clog2(H_TOTAL),
  parameter int unsigned VW      = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last;

  assign h_last = (h_q == HW'(H_TOTAL - 1));
  assign v_last = (v_q == VW'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (tick_i) begin
      if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  p_h_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && h_last) |=> (h_q == '0));
  p_h_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q < HW'(H_TOTAL));
  p_v_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !h_last) |=> $stable(v_q));
  p_v_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && h_last && v_last) |=> (v_q == '0));
endmodule

// File: rtl/tft_out_pipe.sv
module tft_out_pipe
  import tft_timing_pkg::*;
#(
  parameter int unsigned H_ACTIVE  = 800,
  parameter int unsigned V_ACTIVE  = 600,
  parameter int unsigned FETCH_LAT = 1,
  parameter int unsigned HW        = 10,
  parameter int unsigned VW        = 10,
  parameter int unsigned XW        = $clog2(H_ACTIVE),
  parameter int unsigned YW        = $clog2(V_ACTIVE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  pix_t          pix_i,
  output logic          req_o,
  output logic [XW-1:0] req_x_o,
  output logic [YW-1:0] req_y_o,
  output logic          de_o,
  output pix_t          data_o,
  output logic          sof_o
);
  logic act, origin;
  logic sof_q;
  logic [FETCH_LAT-1:0] de_sr, sof_sr;
  logic lat_de, lat_sof;

  assign act    = (h_i < HW'(H_ACTIVE)) && (v_i < VW'(V_ACTIVE));
  assign origin = (h_i == '0) && (v_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      req_x_o <= '0;
      req_y_o <= '0;
      sof_q   <= 1'b0;
    end else if (tick_i) begin
      req_o   <= act;
      req_x_o <= act ? h_i[XW-1:0] : '0;
      req_y_o <= act ? v_i[YW-1:0] : '0;
      sof_q   <= origin;
    end
  end

  // delay line matching the source read latency
  if (FETCH_LAT == 1) begin : g_lat_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        de_sr  <= '0;
        sof_sr <= '0;
      end else if (tick_i) begin
        de_sr  <= req_o;
        sof_sr <= sof_q;
      end
    end
  end else begin : g_lat_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        de_sr  <= '0;
        sof_sr <= '0;
      end else if (tick_i) begin
        de_sr  <= {de_sr[FETCH_LAT-2:0], req_o};
        sof_sr <= {sof_sr[FETCH_LAT-2:0], sof_q};
      end
    end
  end

  assign lat_de  = de_sr[FETCH_LAT-1];
  assign lat_sof = sof_sr[FETCH_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o   <= 1'b0;
      data_o <= '0;
      sof_o  <= 1'b0;
    end else if (tick_i) begin
      de_o   <= lat_de;
      data_o <= lat_de ? pix_i : '0;
      sof_o  <= lat_sof;
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(de_o) && $stable(data_o) && $stable(req_o) && $stable(sof_o)));
  p_sof_on_de_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> de_o);
  p_sof_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && tick_i) |=> !sof_o);
  p_blank_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (data_o == '0));
  p_req_coord_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (req_x_o == '0 && req_y_o == '0));
endmodule

// File: rtl/tft_de_timing.sv
module tft_de_timing #(
  parameter int unsigned H_ACTIVE  = 800,
  parameter int unsigned H_TOTAL   = 860,
  parameter int unsigned V_ACTIVE  = 600,
  parameter int unsigned V_TOTAL   = 615,
  parameter int unsigned FETCH_LAT = 1,
  localparam int unsigned XW = $clog2(H_ACTIVE),
  localparam int unsigned YW = $clog2(V_ACTIVE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [17:0]   pix_i,
  output logic          pclk_o,
  output logic          de_o,
  output logic [17:0]   data_o,
  output logic          sof_o,
  output logic          req_o,
  output logic [XW-1:0] req_x_o,
  output logic [YW-1:0] req_y_o
);
  localparam int unsigned HW = $clog2(H_TOTAL);
  localparam int unsigned VW = $clog2(V_TOTAL);

  logic          tick;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  tft_clk_div u_div (
    .clk_i  (clk_i),
    .pclk_o (pclk_o),
    .tick_o (tick)
  );

  tft_scan_cnt #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .HW      (HW),
    .VW      (VW)
  ) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .h_o    (h_cnt),
    .v_o    (v_cnt)
  );

  tft_out_pipe #(
    .H_ACTIVE  (H_ACTIVE),
    .V_ACTIVE  (V_ACTIVE),
    .FETCH_LAT (FETCH_LAT),
    .HW        (HW),
    .VW        (VW),
    .XW        (XW),
    .YW        (YW)
  ) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .h_i     (h_cnt),
    .v_i     (v_cnt),
    .pix_i   (pix_i),
    .req_o   (req_o),
    .req_x_o (req_x_o),
    .req_y_o (req_y_o),
    .de_o    (de_o),
    .data_o  (data_o),
    .sof_o   (sof_o)
  );

  p_pclk_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |=> !pclk_o);
  p_pclk_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_o |=> pclk_o);
endmodule

// File: tb/tft_de_timing_test.sv
module tft_de_timing_test;
  localparam int HA = 6;
  localparam int HT = 9;
  localparam int VA = 4;
  localparam int VT = 6;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] pix = '1;
  logic        pclk_o, de_o, sof_o, req_o;
  logic [17:0] data_o;
  logic [2:0]  req_x_o;
  logic [1:0]  req_y_o;

  tft_de_timing #(.H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_TOTAL(VT), .FETCH_LAT(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pclk_o(pclk_o), .de_o(de_o),
    .data_o(data_o), .sof_o(sof_o), .req_o(req_o), .req_x_o(req_x_o), .req_y_o(req_y_o)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [17:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [17:0] pat(input int x, input int y);
    return {6'(y + 1), 6'(x + 1), 6'(x * 3 + y + 7)};
  endfunction

  // monitor / driver state
  bit   have_prev = 0, prev_pclk = 0;
  bit   have_lo = 0, lo_de = 0, lo_req = 0, lo_sof = 0;
  logic [17:0] lo_data = '0;
  bit   s_req = 0;
  int   s_x = 0, s_y = 0;
  int   hs = 0;
  bit   req_h1 = 0, req_h2 = 0;
  bit   have_sof = 0, first_rise = 1, prev_de = 0;
  int   since_sof = 0, lines = 0, run = 0, since_rise = 0, pix_idx = 0;
  int   sof_seen = 0;

  // driver: answers the request seen during the previous panel clock
  task automatic drive_pixel();
    lo_de = de_o; lo_req = req_o; lo_sof = sof_o; lo_data = data_o; have_lo = 1;
    if (s_req) begin
      pix = pat(s_x, s_y);
      exp_q.push_back(pix);
    end else begin
      pix = '1;
    end
    s_req = 0;
  endtask

  task automatic monitor_sample();
    hs++;
    if (have_lo)
      chk(de_o == lo_de && data_o == lo_data && req_o == lo_req && sof_o == lo_sof,
          "R2 outputs moved across pclk rise", int'(de_o), int'(lo_de));
    if (!de_o) chk(data_o == '0, "R7 blank data", int'(data_o), 0);
    if (hs >= 3) chk(de_o == req_h2, "R6 de lag", int'(de_o), int'(req_h2));
    if (hs == 2) chk(req_o == 1'b1 && req_x_o == 0 && req_y_o == 0, "R8 first req", int'(req_o), 1);
    if (hs == 4) chk(sof_o && de_o, "R8 first sof", int'(sof_o), 1);
    if (sof_o) begin
      sof_seen++;
      if (have_sof) begin
        chk(since_sof == FRAME, "R4 frame length", since_sof, FRAME);
        chk(lines == VA, "R4 lines per frame", lines, VA);
      end
      chk(de_o, "R5 sof with de", int'(de_o), 1);
      have_sof = 1; since_sof = 0; lines = 0; pix_idx = 0; first_rise = 1;
    end
    if (de_o && !prev_de) begin
      if (!first_rise) chk(since_rise == HT, "R3 line length", since_rise, HT);
      first_rise = 0; lines++; since_rise = 0;
    end
    if (!de_o && prev_de) chk(run == HA, "R3 active run", run, HA);
    if (de_o) begin
      run++;
      if (exp_q.size() == 0) chk(0, "R6 no pixel queued", 0, 1);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk(data_o == e, "R6 data pass-through", int'(data_o), int'(e));
      end
      if (have_sof) chk(data_o == pat(pix_idx % HA, pix_idx / HA), "R6 raster order",
                        int'(data_o), int'(pat(pix_idx % HA, pix_idx / HA)));
      pix_idx++;
    end else begin
      run = 0;
    end
    prev_de = de_o;
    since_sof++;
    since_rise++;
    req_h2 = req_h1; req_h1 = req_o;
    s_req = req_o; s_x = int'(req_x_o); s_y = int'(req_y_o);
  endtask

  always @(negedge clk) begin
    if (have_prev) chk(pclk_o != prev_pclk, "R1 pclk toggle", int'(pclk_o), int'(!prev_pclk));
    have_prev = 1; prev_pclk = pclk_o;
    if (!rst_n) begin
      chk(!de_o && !req_o && !sof_o && data_o == '0 && req_x_o == 0 && req_y_o == 0,
          "R8 reset outputs", int'(de_o | req_o | sof_o), 0);
      pix = '1;
      have_lo = 0; s_req = 0; hs = 0; req_h1 = 0; req_h2 = 0;
      have_sof = 0; prev_de = 0; run = 0; first_rise = 1;
      exp_q.delete();
    end else if (pclk_o) begin
      monitor_sample();
    end else begin
      drive_pixel();
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (9) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2 * FRAME * 2 + 37) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (7) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4 * FRAME * 2 + 20) @(posedge clk);
    chk(sof_seen >= 6, "R5 frames seen", sof_seen, 6);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule